// File: doc/BRIEF.md
# Flash Command Address Translator

This block sits between a register-mapped host port and a flash array engine. It keeps eight 16-bit start-address registers and a start-buffer register. When the host strobes a command, it turns the selected block and page registers into a flat index of 512-byte sectors. It passes that index on, together with an on-chip buffer select, a sector count and an operation code. The result is registered and marked by a one-cycle valid pulse.

A boot-area write path provides a two-step load. The first boot write arms the block and the second one fires it. On firing, one whole page from the source block/page is sent to data buffer 0, and the page register moves forward by one page. The array storage, error correction and spare-area data are handled elsewhere.

The page geometry is set by a parameter: four sectors per page (2 KB pages) by default, or two. An optional density mask serves parts with two dies. When it is non-zero, bit 15 of a block register ORs the mask into the block field, which selects the upper die.

Top module: `flash_cmd_xlate`

## Requirements
- R1: After reset, every address register and the start-buffer readback read 0, the sector count is 1, no load is armed, and `out_valid` is low.
- R2: A write with `reg_sel` 0..7 stores all 16 bits of `reg_wdata` in address register `reg_sel`, and a read at that select returns the stored value.
- R3: `cmd_stb` with `cmd_op`=0 (source) produces `out_valid` on the next cycle with `out_op`=0 and `out_sector` = P[1:0] + ((P[7:2] + (F << 6)) << 2). Here P is register 7 and F is the block field of register 0. The values used are those held before the strobe edge, so a register write in the same cycle is not seen.
- R4: The block field F is bits 11:0 of the block register. When bit 15 of that register is set, F is ORed with the density mask (default 0x1000). Bits 14:12 are not used.
- R5: `cmd_op`=1 (destination) works as R3 but takes the block from register 2 and the page from register 3, with `out_op`=1.
- R6: `cmd_op`=2 (block erase) reports `out_op`=2, `out_sector` = F(register 0) << 8 and `out_count` = 256.
- R7: A write with `reg_sel`=8 sets the buffer address from bits 11:8 and the count from bits 1:0, where a field of 0 means 4. Commands 0..2 report this buffer address on `out_buf` and this count on `out_count`, except that an erase always reports 256. In the buffer address, bit 3 set means a data buffer, bit 2 picks one of the two data buffers, and bits 1:0 pick the sector within the buffer.
- R8: A read with `reg_sel`=8 returns (bufaddr << 8) | ((count-1) & 2).
- R9: A write with `reg_sel`=9 (boot area) of 0x00E0 arms a load. If the next boot write is 0x0000, the block issues `out_op`=3 with the source sector of R3, `out_buf`=4'b1000 and `out_count`=4. In the same cycle, register 7 becomes (register 7 + 4) & 0x00FF.
- R10: Once armed, the next boot write always disarms, whatever its value. A non-zero value issues nothing, and a later 0x0000 issues nothing either.
- R11: While not armed, a boot write of any value other than 0x00E0 (0x0000 included) issues nothing and leaves register 7 unchanged.
- R12: Each issue gives exactly one cycle of `out_valid`. `out_op`, `out_sector`, `out_buf` and `out_count` hold their last values until the next issue.
- R13: `cmd_op`=3 issues nothing. A `cmd_stb` in the same cycle as a firing boot write is dropped, and only the boot load is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select: 0..7 address, 8 start buffer, 9 boot area |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_sel` (combinational) |
| cmd_stb | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 source, 1 destination, 2 block erase, 3 none |
| out_valid | output | 1 | One-cycle issue pulse |
| out_op | output | 2 | Issued operation, 3 = boot load |
| out_sector | output | 21 | Flat 512-byte sector index |
| out_buf | output | 4 | Buffer select |
| out_count | output | 9 | Sector count |

## Verification
If the register state goes wrong, the next issue shows it on `out_sector`, `out_buf` or `out_count`, one cycle after the strobe. The scoreboard compares every pulse against a model built from the requirements. A wrong arm state shows up as a boot load that is missing or unexpected on the cycle after the second boot write. It also shows up in the register 7 readback, which is read directly after each boot sequence. Stale or shifted page-step arithmetic shows up in the readback as well. It also shows up in the sector of the following load, which covers the wrap past 0xFC and the clearing of the upper byte.

// File: rtl/flash_xlate_pkg.sv
package flash_xlate_pkg;
   typedef enum logic [1:0] {
      OP_SRC   = 2'd0,
      OP_DST   = 2'd1,
      OP_ERASE = 2'd2,
      OP_BOOT  = 2'd3
   } xl_op_e;

   localparam int          NUM_AREG    = 8;
   localparam int          IDX_SRC_BLK = 0;
   localparam int          IDX_DST_BLK = 2;
   localparam int          IDX_DST_PG  = 3;
   localparam int          IDX_SRC_PG  = 7;
   localparam logic [3:0]  SEL_BUF     = 4'd8;
   localparam logic [3:0]  SEL_BOOT    = 4'd9;
   localparam logic [15:0] BOOT_ARM    = 16'h00E0;
   localparam logic [15:0] BOOT_FIRE   = 16'h0000;
   localparam logic [3:0]  BOOT_BUFSEL = 4'b1000;
endpackage

// File: rtl/xl_addr_regs.sv
module xl_addr_regs
   import flash_xlate_pkg::*;
#(
   parameter int SPL = 2,
   localparam int CW = SPL + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [3:0]    sel,
   input  logic [15:0]   wr_data,
   input  logic          page_step,
   output logic [15:0]   rd_data,
   output logic [12:0]   src_blk,
   output logic [7:0]    src_page,
   output logic [12:0]   dst_blk,
   output logic [7:0]    dst_page,
   output logic [3:0]    buf_addr,
   output logic [CW-1:0] sec_count
);
   logic [15:0]   areg [NUM_AREG];
   logic [SPL-1:0] cnt_field;
   logic [CW-1:0]  cnt_dec;
   logic [CW-1:0]  cnt_m1;

   for (genvar i = 0; i < NUM_AREG; i++) begin : g_areg
      logic [15:0] q;
      if (i == IDX_SRC_PG) begin : g_step
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= '0;
            else if (page_step)
               q <= {8'h00, q[7:0] + 8'd4};
            else if (wr_en && sel == 4'(i))
               q <= wr_data;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && sel == 4'(i))
               q <= wr_data;
         end
      end
      assign areg[i] = q;
   end

   assign cnt_field = wr_data[SPL-1:0];
   assign cnt_dec   = (cnt_field == '0) ? CW'(1 << SPL) : CW'(cnt_field);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_addr  <= '0;
         sec_count <= CW'(1);
      end else if (wr_en && sel == SEL_BUF) begin
         buf_addr  <= wr_data[11:8];
         sec_count <= cnt_dec;
      end
   end

   assign cnt_m1 = sec_count - CW'(1);

   always_comb begin
      if (!sel[3])
         rd_data = areg[sel[2:0]];
      else if (sel == SEL_BUF)
         rd_data = {4'h0, buf_addr, 8'h00} | 16'(cnt_m1 & CW'(1 << (SPL - 1)));
      else
         rd_data = '0;
   end

   assign src_blk  = {areg[IDX_SRC_BLK][15], areg[IDX_SRC_BLK][11:0]};
   assign src_page = areg[IDX_SRC_PG][7:0];
   assign dst_blk  = {areg[IDX_DST_BLK][15], areg[IDX_DST_BLK][11:0]};
   assign dst_page = areg[IDX_DST_PG][7:0];
endmodule

// File: rtl/xl_sector_calc.sv
module xl_sector_calc #(
   parameter int BLK_W = 13,
   parameter int SPL = 2,
   parameter logic [BLK_W-1:0] DENSITY_MASK = BLK_W'(13'h1000),
   localparam int SEC_W = BLK_W + 6 + SPL
) (
   input  logic [12:0]      blk,
   input  logic [7:0]       page,
   output logic [SEC_W-1:0] page_sector,
   output logic [SEC_W-1:0] block_sector
);
   logic [BLK_W-1:0] base;
   logic [BLK_W-1:0] field;

   assign base = BLK_W'(blk[11:0]);

   if (DENSITY_MASK == '0) begin : g_single_die
      logic unused_die;
      assign unused_die = blk[12];
      assign field = base;
   end else begin : g_dual_die
      assign field = blk[12] ? (base | DENSITY_MASK) : base;
   end

   assign page_sector  = SEC_W'(page[1:0])
                       + ((SEC_W'(page[7:2]) + (SEC_W'(field) << 6)) << SPL);
   assign block_sector = SEC_W'(field) << (SPL + 6);
endmodule

// File: rtl/xl_boot_seq.sv
module xl_boot_seq
   import flash_xlate_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        boot_wr,
   input  logic [15:0] wr_data,
   output logic        armed,
   output logic        fire
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         armed <= 1'b0;
      else if (boot_wr)
         armed <= !armed && (wr_data == BOOT_ARM);
   end

   assign fire = boot_wr && armed && (wr_data == BOOT_FIRE);
endmodule

// File: rtl/flash_cmd_xlate.sv
module flash_cmd_xlate
   import flash_xlate_pkg::*;
#(
   parameter int BLK_W = 13,
   parameter int SPL = 2,
   parameter logic [BLK_W-1:0] DENSITY_MASK = BLK_W'(13'h1000),
   localparam int SEC_W = BLK_W + 6 + SPL,
   localparam int CNT_W = SPL + 7,
   localparam int CW = SPL + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [3:0]       reg_sel,
   input  logic [15:0]      reg_wdata,
   output logic [15:0]      reg_rdata,
   input  logic             cmd_stb,
   input  logic [1:0]       cmd_op,
   output logic             out_valid,
   output logic [1:0]       out_op,
   output logic [SEC_W-1:0] out_sector,
   output logic [3:0]       out_buf,
   output logic [CNT_W-1:0] out_count
);
   if (SPL < 1 || SPL > 2) begin : g_bad_spl
      $error("SPL must be 1 or 2");
   end
   if (BLK_W < 12 || BLK_W > 24) begin : g_bad_blkw
      $error("BLK_W must be 12..24");
   end

   logic [12:0]      src_blk, dst_blk;
   logic [7:0]       src_page, dst_page;
   logic [3:0]       buf_addr;
   logic [CW-1:0]    sec_count;
   logic             boot_wr, boot_armed, boot_fire;
   logic [SEC_W-1:0] src_sec, dst_sec, erase_sec, unused_sec;
   logic             issue_cmd;

   assign boot_wr = reg_wr && (reg_sel == SEL_BOOT);

   xl_addr_regs #(.SPL(SPL)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr),
      .sel       (reg_sel),
      .wr_data   (reg_wdata),
      .page_step (boot_fire),
      .rd_data   (reg_rdata),
      .src_blk   (src_blk),
      .src_page  (src_page),
      .dst_blk   (dst_blk),
      .dst_page  (dst_page),
      .buf_addr  (buf_addr),
      .sec_count (sec_count)
   );

   xl_boot_seq u_boot (
      .clk     (clk),
      .rst_n   (rst_n),
      .boot_wr (boot_wr),
      .wr_data (reg_wdata),
      .armed   (boot_armed),
      .fire    (boot_fire)
   );

   xl_sector_calc #(.BLK_W(BLK_W), .SPL(SPL), .DENSITY_MASK(DENSITY_MASK)) u_src (
      .blk          (src_blk),
      .page         (src_page),
      .page_sector  (src_sec),
      .block_sector (erase_sec)
   );

   xl_sector_calc #(.BLK_W(BLK_W), .SPL(SPL), .DENSITY_MASK(DENSITY_MASK)) u_dst (
      .blk          (dst_blk),
      .page         (dst_page),
      .page_sector  (dst_sec),
      .block_sector (unused_sec)
   );

   assign issue_cmd = cmd_stb && (cmd_op != OP_BOOT) && !boot_fire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_op     <= OP_SRC;
         out_sector <= '0;
         out_buf    <= '0;
         out_count  <= '0;
      end else begin
         out_valid <= boot_fire || issue_cmd;
         if (boot_fire) begin
            out_op     <= OP_BOOT;
            out_sector <= src_sec;
            out_buf    <= BOOT_BUFSEL;
            out_count  <= CNT_W'(1 << SPL);
         end else if (issue_cmd) begin
            out_op  <= cmd_op;
            out_buf <= buf_addr;
            case (cmd_op)
               OP_DST: begin
                  out_sector <= dst_sec;
                  out_count  <= CNT_W'(sec_count);
               end
               OP_ERASE: begin
                  out_sector <= erase_sec;
                  out_count  <= CNT_W'(1 << (SPL + 6));
               end
               default: begin
                  out_sector <= src_sec;
                  out_count  <= CNT_W'(sec_count);
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/xl_checker.sv
module xl_checker
   import flash_xlate_pkg::*;
#(
   parameter int SEC_W = 21,
   parameter int CNT_W = 9,
   parameter int SPL = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [3:0]       reg_sel,
   input logic [15:0]      reg_wdata,
   input logic             cmd_stb,
   input logic [1:0]       cmd_op,
   input logic             armed,
   input logic             out_valid,
   input logic [1:0]       out_op,
   input logic [SEC_W-1:0] out_sector,
   input logic [3:0]       out_buf,
   input logic [CNT_W-1:0] out_count
);
   logic boot_w;
   assign boot_w = reg_wr && (reg_sel == SEL_BOOT);

   assert_erase_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_op == OP_ERASE) |->
         (out_sector[SPL+5:0] == '0 && out_count == CNT_W'(1 << (SPL + 6))));

   assert_boot_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_op == OP_BOOT) |->
         (out_buf == BOOT_BUFSEL && out_count == CNT_W'(1 << SPL)));

   assert_count_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_count != '0));

   assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_stb || boot_w) |=>
         (!out_valid && $stable(out_sector) && $stable(out_count)
          && $stable(out_buf) && $stable(out_op)));

   assert_arm_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(boot_w && reg_wdata == BOOT_ARM));

   assert_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && boot_w) |=> !armed);

   assert_no_op3_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stb && cmd_op == OP_BOOT && !boot_w) |=> !out_valid);
endmodule

bind flash_cmd_xlate xl_checker #(.SEC_W(SEC_W), .CNT_W(CNT_W), .SPL(SPL)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_sel    (reg_sel),
   .reg_wdata  (reg_wdata),
   .cmd_stb    (cmd_stb),
   .cmd_op     (cmd_op),
   .armed      (boot_armed),
   .out_valid  (out_valid),
   .out_op     (out_op),
   .out_sector (out_sector),
   .out_buf    (out_buf),
   .out_count  (out_count)
);

// File: tb/sim_flash_cmd_xlate.sv
module sim_flash_cmd_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_sel = 4'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata;
   logic        cmd_stb = 1'b0;
   logic [1:0]  cmd_op = 2'd0;
   logic        out_valid;
   logic [1:0]  out_op;
   logic [20:0] out_sector;
   logic [3:0]  out_buf;
   logic [8:0]  out_count;

   int vectors = 0;
   int miscompares = 0;

   logic [35:0] exp_q[$];
   string       tag_q[$];
   logic [35:0] last_item;

   logic [15:0] sh_reg [8];
   logic [3:0]  sh_buf;
   logic [8:0]  sh_cnt;
   logic        sh_armed;

   always #10 clk = ~clk;

   flash_cmd_xlate u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_stb(cmd_stb),
      .cmd_op(cmd_op), .out_valid(out_valid), .out_op(out_op),
      .out_sector(out_sector), .out_buf(out_buf), .out_count(out_count)
   );

   function automatic logic [12:0] f_field(input logic [15:0] b);
      return {1'b0, b[11:0]} | (b[15] ? 13'h1000 : 13'h0000);
   endfunction

   function automatic logic [20:0] f_sec(input logic [15:0] b, input logic [15:0] p);
      return 21'(p[1:0]) + ((21'(p[7:2]) + (21'(f_field(b)) << 6)) << 2);
   endfunction

   function automatic logic [35:0] f_item(input logic [1:0] op, input logic [20:0] s,
                                          input logic [3:0] bsel, input logic [8:0] c);
      return {op, s, bsel, c};
   endfunction

   task automatic push(input logic [35:0] it, input string tag);
      exp_q.push_back(it);
      tag_q.push_back(tag);
   endtask

   task automatic check(input bit ok, input string tag, input logic [35:0] act,
                        input logic [35:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // model of one cycle of host activity, from the requirements
   task automatic model_cycle(input bit w, input logic [3:0] s, input logic [15:0] d,
                              input bit c, input logic [1:0] op, input string tag);
      bit fire;
      logic [15:0] r7;
      fire = 1'b0;
      if (w && s == 4'd9) begin
         fire = sh_armed && d == 16'h0000;
         sh_armed = !sh_armed && d == 16'h00E0;
      end
      if (fire)
         push(f_item(2'd3, f_sec(sh_reg[0], sh_reg[7]), 4'b1000, 9'd4), tag);
      else if (c && op != 2'd3) begin
         case (op)
            2'd0: push(f_item(2'd0, f_sec(sh_reg[0], sh_reg[7]), sh_buf, sh_cnt), tag);
            2'd1: push(f_item(2'd1, f_sec(sh_reg[2], sh_reg[3]), sh_buf, sh_cnt), tag);
            default: push(f_item(2'd2, 21'(f_field(sh_reg[0])) << 8, sh_buf, 9'd256), tag);
         endcase
      end
      if (fire) begin
         r7 = sh_reg[7];
         sh_reg[7] = {8'h00, r7[7:0] + 8'd4};
      end else if (w && s < 4'd8)
         sh_reg[s[2:0]] = d;
      else if (w && s == 4'd8) begin
         sh_buf = d[11:8];
         sh_cnt = (d[1:0] == 2'd0) ? 9'd4 : 9'(d[1:0]);
      end
   endtask

   task automatic drive(input bit w, input logic [3:0] s, input logic [15:0] d,
                        input bit c, input logic [1:0] op, input string tag);
      @(negedge clk);
      reg_wr = w; reg_sel = s; reg_wdata = d; cmd_stb = c; cmd_op = op;
      model_cycle(w, s, d, c, op, tag);
      @(negedge clk);
      reg_wr = 1'b0; cmd_stb = 1'b0;
   endtask

   task automatic wr(input logic [3:0] s, input logic [15:0] d, input string tag);
      drive(1'b1, s, d, 1'b0, 2'd0, tag);
   endtask

   task automatic cmd(input logic [1:0] op, input string tag);
      drive(1'b0, 4'd0, 16'd0, 1'b1, op, tag);
   endtask

   task automatic rd_chk(input logic [3:0] s, input logic [15:0] exp, input string tag);
      @(negedge clk);
      reg_sel = s;
      #1;
      check(reg_rdata === exp, tag, 36'(reg_rdata), 36'(exp));
   endtask

   // monitor: pops one expected item per valid pulse
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0)
            check(1'b0, "R12 unexpected valid", {out_op, out_sector, out_buf, out_count}, 36'd0);
         else begin
            logic [35:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            last_item = e;
            check({out_op, out_sector, out_buf, out_count} === e, t,
                  {out_op, out_sector, out_buf, out_count}, e);
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) sh_reg[i] = 16'd0;
      sh_buf = 4'd0; sh_cnt = 9'd1; sh_armed = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid === 1'b0, "R1 valid after reset", 36'(out_valid), 36'd0);
      for (int i = 0; i < 9; i++) rd_chk(4'(i), 16'h0000, "R1 readback after reset");
      // R11: unarmed fire value does nothing (also shows R1 disarmed)
      wr(4'd9, 16'h0000, "R11");
      wr(4'd9, 16'h1234, "R11");
      rd_chk(4'd7, 16'h0000, "R11 page untouched");

      // R2 / R3
      wr(4'd0, 16'h0123, "R2");
      wr(4'd7, 16'h00B6, "R2");
      wr(4'd2, 16'hA5A5, "R2");
      rd_chk(4'd0, 16'h0123, "R2 reg0");
      rd_chk(4'd7, 16'h00B6, "R2 reg7");
      rd_chk(4'd2, 16'hA5A5, "R2 reg2");
      cmd(2'd0, "R3 source, count 1");
      // R4 density
      wr(4'd0, 16'h8FFF, "R4");
      cmd(2'd0, "R4 upper die source");
      wr(4'd0, 16'h7005, "R4");
      cmd(2'd0, "R4 bits 14:12 ignored");
      // R5
      wr(4'd2, 16'h0040, "R5");
      wr(4'd3, 16'h00FF, "R5");
      cmd(2'd1, "R5 destination");
      // R6
      cmd(2'd2, "R6 erase");
      wr(4'd0, 16'h8001, "R6");
      cmd(2'd2, "R6 erase upper die");
      // R7 / R8
      wr(4'd8, 16'h0A03, "R7");
      rd_chk(4'd8, 16'h0A02, "R8 count 3");
      cmd(2'd0, "R7 count 3");
      wr(4'd8, 16'h0C00, "R7");
      rd_chk(4'd8, 16'h0C02, "R8 count 4");
      cmd(2'd1, "R7 count 0 means 4");
      wr(4'd8, 16'h0501, "R7");
      rd_chk(4'd8, 16'h0500, "R8 count 1");
      wr(4'd8, 16'hFF02, "R7");
      rd_chk(4'd8, 16'h0F00, "R8 count 2");
      cmd(2'd0, "R7 count 2");
      // R9 boot load, with wrap
      wr(4'd0, 16'h0010, "R9");
      wr(4'd7, 16'h12FE, "R9");
      wr(4'd9, 16'h00E0, "R9");
      wr(4'd9, 16'h0000, "R9 boot load");
      rd_chk(4'd7, 16'h0002, "R9 page wrap");
      wr(4'd9, 16'h00E0, "R9");
      wr(4'd9, 16'h0000, "R9 second boot load");
      rd_chk(4'd7, 16'h0006, "R9 page step");
      // R10
      wr(4'd9, 16'h00E0, "R10");
      wr(4'd9, 16'h1234, "R10");
      wr(4'd9, 16'h0000, "R10");
      rd_chk(4'd7, 16'h0006, "R10 no step");
      wr(4'd9, 16'h00E0, "R10");
      wr(4'd9, 16'h00E0, "R10");
      wr(4'd9, 16'h0000, "R10");
      rd_chk(4'd7, 16'h0006, "R10 double arm");
      // R3 same-cycle write is not seen
      drive(1'b1, 4'd7, 16'h0031, 1'b1, 2'd0, "R3 same-cycle write");
      rd_chk(4'd7, 16'h0031, "R3 write landed");
      // R13
      cmd(2'd3, "R13");
      wr(4'd9, 16'h00E0, "R13");
      drive(1'b1, 4'd9, 16'h0000, 1'b1, 2'd1, "R13 boot beats command");
      // R12 hold
      repeat (3) @(negedge clk);
      check({out_op, out_sector, out_buf, out_count} === last_item && out_valid === 1'b0,
            "R12 hold", {out_op, out_sector, out_buf, out_count}, last_item);

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R12 missing issue", 36'(exp_q.size()), 36'd0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule